// File: doc/BRIEF.md
# Grouped-Lookahead Cascaded Carry Adder

A purely combinational unsigned adder of two 32-bit operands. It produces a 32-bit sum and a separate carry-out, so no overflow bit is lost. Each bit's propagate is the XOR of its operand bits and its generate is their AND. The width is cut into eight 4-bit groups. The carry passes from one group to the next.

Inside a group, every look-ahead carry is split into two parts, a group generate and a group propagate. Neither part depends on the group's incoming carry, so both are settled before that carry arrives. The incoming carry enters only through one final AND-OR stage per carry. The chain from the lowest group to the carry-out therefore crosses one AND-OR level per group, not a wide AND/OR tree.

The lowest group has no incoming carry. Its carries are the generate parts alone. No AND or OR term in the grouping is wider than four inputs.

Top module: `gla_adder`

## Requirements
- R1: `sum_o` equals the low 32 bits of `a_i + b_i` for every operand pair.
- R2: `carry_o` equals bit 32 of the 33-bit sum `a_i + b_i`.
- R3: The carry leaving group k (bits 4k+3..4k) equals bit 4 of the 5-bit sum of that group's operand slices plus the carry entering the group. A carry made in any group reaches `carry_o` through all higher groups when their slices fully propagate.
- R4: Within a group, the group generate and the group propagate are never both 1. Operand pairs with no propagating bit (`a_i == b_i`) give `sum_o = a_i << 1` and `carry_o = a_i[31]`.
- R5: The lowest group sees a carry-in of 0, so 0 + 0 gives `sum_o = 0` and `carry_o = 0`.
- R6: 0xFFFFFFFF + 1 gives `sum_o = 0` and `carry_o = 1`, a propagate across all eight groups.
- R7: 0xFFFFFFFF + 0xFFFFFFFF gives `sum_o = 0xFFFFFFFE` and `carry_o = 1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | first unsigned operand |
| b_i | input | 32 | second unsigned operand |
| sum_o | output | 32 | low 32 bits of the sum |
| carry_o | output | 1 | carry out of the most significant group |

## Verification
The hardest situation to reach is a carry born in one group that must cross every higher group through the propagate path alone. Random operands almost never make every higher 4-bit slice fully propagate. The stimulus therefore builds that case for each group in turn. It sets a generating bit at the group's lowest position and places propagating bits (one operand 1, the other 0) in all bits above. This makes the sum 0 from that group upward and forces `carry_o` to 1. The saturating corner cases and the equal-operand pairs, which have no propagate at all, complete the picture.

// File: rtl/gla_pkg.sv
package gla_pkg;
  localparam int unsigned GRP_W = 4;

  // carry-independent parts of each look-ahead carry in a group
  typedef struct packed {
    logic [GRP_W-1:0] gen;
    logic [GRP_W-1:0] prp;
  } grp_terms_t;
endpackage

// File: rtl/gla_bit_pg.sv
module gla_bit_pg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] p_o,
  output logic [WIDTH-1:0] g_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign p_o[i] = a_i[i] ^ b_i[i];
    assign g_o[i] = a_i[i] & b_i[i];
  end
endmodule

// File: rtl/gla_grp_terms.sv
module gla_grp_terms
  import gla_pkg::*;
(
  input  logic [GRP_W-1:0] p_i,
  input  logic [GRP_W-1:0] g_i,
  output grp_terms_t       terms_o
);
  if (GRP_W != 4) begin : g_bad_width
    initial $error("gla_grp_terms expects 4-bit groups");
  end

  // flat sum-of-products, every term at most four literals
  assign terms_o.gen[0] = g_i[0];
  assign terms_o.prp[0] = p_i[0];

  assign terms_o.gen[1] = g_i[1] | (p_i[1] & g_i[0]);
  assign terms_o.prp[1] = p_i[1] & p_i[0];

  assign terms_o.gen[2] = g_i[2] | (p_i[2] & g_i[1]) | (p_i[2] & p_i[1] & g_i[0]);
  assign terms_o.prp[2] = p_i[2] & p_i[1] & p_i[0];

  assign terms_o.gen[3] = g_i[3] | (p_i[3] & g_i[2]) | (p_i[3] & p_i[2] & g_i[1])
                        | (p_i[3] & p_i[2] & p_i[1] & g_i[0]);
  assign terms_o.prp[3] = p_i[3] & p_i[2] & p_i[1] & p_i[0];
endmodule

// File: rtl/gla_grp_carry.sv
module gla_grp_carry
  import gla_pkg::*;
#(
  parameter bit HAS_CIN = 1'b1
) (
  input  grp_terms_t       terms_i,
  input  logic             cin_i,
  output logic [GRP_W-1:0] c_o
);
  if (HAS_CIN) begin : g_ao21
    // single AND-OR level on the carry path
    for (genvar j = 0; j < GRP_W; j++) begin : g_c
      assign c_o[j] = terms_i.gen[j] | (terms_i.prp[j] & cin_i);
    end
  end else begin : g_no_cin
    logic unused_cin;
    assign unused_cin = ^{cin_i, terms_i.prp};
    assign c_o        = terms_i.gen;
  end
endmodule

// File: rtl/gla_adder.sv
module gla_adder
  import gla_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  localparam int unsigned N_GRP = WIDTH / GRP_W;

  if (WIDTH % GRP_W != 0) begin : g_bad_width
    initial $error("WIDTH must be a multiple of the group width");
  end

  logic [WIDTH-1:0] p, g;
  logic [WIDTH:0]   c;
  logic [N_GRP-1:0] grp_gen, grp_prp;

  gla_bit_pg #(.WIDTH(WIDTH)) i_pg (
    .a_i (a_i),
    .b_i (b_i),
    .p_o (p),
    .g_o (g)
  );

  assign c[0] = 1'b0;

  for (genvar k = 0; k < N_GRP; k++) begin : g_grp
    grp_terms_t terms;

    gla_grp_terms i_terms (
      .p_i     (p[k*GRP_W +: GRP_W]),
      .g_i     (g[k*GRP_W +: GRP_W]),
      .terms_o (terms)
    );

    gla_grp_carry #(.HAS_CIN(k != 0)) i_carry (
      .terms_i (terms),
      .cin_i   (c[k*GRP_W]),
      .c_o     (c[k*GRP_W+1 +: GRP_W])
    );

    assign grp_gen[k] = terms.gen[GRP_W-1];
    assign grp_prp[k] = terms.prp[GRP_W-1];
  end

  assign sum_o   = p ^ c[WIDTH-1:0];
  assign carry_o = c[WIDTH];
endmodule

// File: rtl/gla_adder_chk.sv
module gla_adder_chk
  import gla_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned N_GRP = WIDTH / GRP_W
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o,
  input logic [WIDTH:0]   c,
  input logic [N_GRP-1:0] grp_gen,
  input logic [N_GRP-1:0] grp_prp
);
  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    // R1 and R2
    a_r1_r2_total: assert ({carry_o, sum_o} == ref_total)
      else $error("total mismatch");
    for (int k = 0; k < N_GRP; k++) begin
      automatic logic [GRP_W:0] slice_sum =
        {1'b0, a_i[k*GRP_W +: GRP_W]} + {1'b0, b_i[k*GRP_W +: GRP_W]}
        + {{GRP_W{1'b0}}, c[k*GRP_W]};
      a_r3_grp_carry: assert (c[(k+1)*GRP_W] == slice_sum[GRP_W])
        else $error("group carry mismatch");
      a_r3_grp_prp: assert (grp_prp[k] == &(a_i[k*GRP_W +: GRP_W] ^ b_i[k*GRP_W +: GRP_W]))
        else $error("group propagate mismatch");
      a_r4_gen_prp_excl: assert (!(grp_gen[k] && grp_prp[k]))
        else $error("generate and propagate both set");
    end
  end
endmodule

bind gla_adder gla_adder_chk #(.WIDTH(WIDTH)) i_gla_adder_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .sum_o   (sum_o),
  .carry_o (carry_o),
  .c       (c),
  .grp_gen (grp_gen),
  .grp_prp (grp_prp)
);

// File: tb/test_gla_adder.sv
module test_gla_adder;
  localparam int unsigned WIDTH      = 32;
  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned N_RAND     = 1000;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [WIDTH-1:0] a, b, sum;
  logic             co;

  int n_chk  = 0;
  int n_fail = 0;

  typedef struct {
    logic [WIDTH:0] exp;
    string          tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gla_adder #(.WIDTH(WIDTH)) i_gla_adder (
    .a_i     (a),
    .b_i     (b),
    .sum_o   (sum),
    .carry_o (co)
  );

  // behavioural reference: plain integer addition
  function automatic logic [WIDTH:0] ref_add(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y);
    longint unsigned t = longint'(x) + longint'(y);
    return t[WIDTH:0];
  endfunction

  task automatic apply(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y,
                       input string tag);
    exp_t e;
    @(negedge clk);
    a = x;
    b = y;
    e.exp = ref_add(x, y);
    e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic compare();
    exp_t e = exp_q.pop_front();
    n_chk++;
    if ({co, sum} !== e.exp) begin
      n_fail++;
      $display("FAIL %s: actual carry=%0b sum=%08h expected carry=%0b sum=%08h",
               e.tag, co, sum, e.exp[WIDTH], e.exp[WIDTH-1:0]);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    a = '0;
    b = '0;
    repeat (3) @(posedge clk);
    #1;
    // R5 reset-time state: zero operands give zero outputs
    exp_q.push_back('{exp: '0, tag: "R5 reset"});
    compare();
    @(negedge clk);
    rst_ni = 1'b1;

    apply('0, '0, "R5 zero plus zero");
    apply('1, 32'd1, "R6 all ones plus one");
    apply(32'd1, '1, "R6 one plus all ones");
    apply('1, '1, "R7 all ones plus all ones");
    apply('1, '0, "R3 full propagate no carry");

    // R3: carry born in group k ripples through all higher groups
    for (int k = 0; k < WIDTH / 4; k++) begin
      logic [WIDTH-1:0] hi = '1 << (4 * k);
      apply(hi, 32'd1 << (4 * k), "R3 group carry chain");
      apply(32'd1 << (4 * k + 3), 32'd1 << (4 * k + 3), "R3 group top generate");
    end

    // R4: no propagating bit anywhere
    for (int i = 0; i < 16; i++) begin
      logic [WIDTH-1:0] v = $urandom;
      apply(v, v, "R4 equal operands");
    end

    // R1 R2 random pairs
    for (int i = 0; i < N_RAND; i++) begin
      apply($urandom, $urandom, "R1 R2 random");
    end

    finish_run();
  end
endmodule